// File: doc/BRIEF.md
# Video Address Mirroring Decoder

This block maps a 16-bit video memory request onto the storage behind it. The top two address bits are dropped, which leaves a 14-bit space. That space holds three targets: pattern memory at 0x0000-0x1FFF, four nametable quadrants at 0x2000-0x2FFF (also reached again at 0x3000-0x3EFF), and a 32-entry palette at 0x3F00-0x3FFF. The palette repeats every 32 bytes, and the four backdrop slots of its upper half fold onto the lower half.

Two nametable pages and the palette RAM sit inside the block. Pattern memory sits outside it. It is reached through an external port whose address carries a bank number, and writes to it are suppressed when it is marked read-only. A mirroring-mode input decides how the four nametable quadrants land on the two internal pages. In four-page mode, nametable traffic is sent to the external port instead, tagged as nametable traffic. Read data returns one cycle after the request, whichever target served it.

Top module: `vam_top`

## Requirements
- R1: Address bits 15:14 are ignored; any address and the same address with different bits 15:14 reach the same location.
- R2: Addresses 0x3000-0x3EFF reach the same nametable locations as 0x2000-0x2EFF, including 0x3EFF, which reaches 0x2EFF.
- R3: Palette space 0x3F00-0x3FFF selects entry addr[4:0], so the 32 entries repeat eight times.
- R4: Palette entries 0x10, 0x14, 0x18 and 0x1C share storage with 0x00, 0x04, 0x08 and 0x0C; the other upper entries (e.g. 0x11) stay distinct from their lower neighbours.
- R5: Entries 0x00, 0x04, 0x08 and 0x0C hold independent values.
- R6: With mirror_i = 2'b00 (horizontal), quadrants 0x2000 and 0x2400 share one page and 0x2800 and 0x2C00 share the other (page = addr[11]).
- R7: With mirror_i = 2'b01 (vertical), quadrants 0x2000 and 0x2800 share one page and 0x2400 and 0x2C00 share the other (page = addr[10]).
- R8: With mirror_i = 2'b10 (single page), all four quadrants reach page 0.
- R9: With mirror_i = 2'b11 (four page), nametable accesses drive ext_req_o with ext_nt_o = 1 and ext_addr_o = addr[11:0] zero-extended, read data comes from ext_rdata_i, and the internal pages are not written.
- R10: Accesses to 0x0000-0x1FFF drive ext_req_o with ext_nt_o = 0 and ext_addr_o = {bank_i, addr[12:0]}; reads return ext_rdata_i.
- R11: A pattern write with pat_ro_i = 1 asserts neither ext_we_o nor ext_req_o; with pat_ro_i = 0 it asserts both.
- R12: A read asserts rvalid_o with its data on rdata_o exactly one cycle later; a write or an idle cycle yields rvalid_o = 0 in the following cycle.
- R13: During and right after reset, rvalid_o = 0 and rdata_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Video address |
| wdata_i | input | DW | Write data |
| mirror_i | input | 2 | Nametable mode: 00 horizontal, 01 vertical, 10 single, 11 four page |
| bank_i | input | BANK_W | Pattern memory bank number |
| pat_ro_i | input | 1 | Pattern memory is read-only |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DW | Read data |
| ext_req_o | output | 1 | External access strobe |
| ext_we_o | output | 1 | External write strobe |
| ext_nt_o | output | 1 | External access targets nametable (1) or pattern (0) |
| ext_addr_o | output | BANK_W+13 | External address |
| ext_wdata_o | output | DW | External write data |
| ext_rdata_i | input | DW | External read data, valid in the request cycle |

## Verification
The external strobes, address and write data are combinational in the request cycle. The bench therefore compares them 1 ns after it drives the request on the falling edge. Read data from every target becomes visible one rising edge after the request. Each read pushes its expected byte into a queue. A monitor pops that byte 2 ns after the next rising edge and compares it with rdata_o. The monitor also flags an rvalid_o that has no matching entry, and an entry that no rvalid_o answers.

// File: rtl/vam_pkg.sv
package vam_pkg;
  localparam int VA_W   = 16;
  localparam int FOLD_W = 14;
  localparam int PAT_W  = 13;
  localparam int NT_AW  = 10;
  localparam int NT_PGS = 2;
  localparam int PAL_AW = 5;
  localparam int XNT_W  = 12;

  typedef enum logic [1:0] {
    NT_HORZ = 2'b00,
    NT_VERT = 2'b01,
    NT_ONE  = 2'b10,
    NT_FOUR = 2'b11
  } nt_map_e;

  typedef enum logic [1:0] {
    TGT_PAT = 2'b00,
    TGT_NT  = 2'b01,
    TGT_PAL = 2'b10,
    TGT_XNT = 2'b11
  } tgt_e;
endpackage

// File: rtl/vam_decode.sv
module vam_decode
  import vam_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int EXT_AW = BANK_W + PAT_W
) (
  input  logic [VA_W-1:0]   addr_i,
  input  nt_map_e           mode_i,
  input  logic [BANK_W-1:0] bank_i,
  output tgt_e              tgt_o,
  output logic              nt_page_o,
  output logic [NT_AW-1:0]  nt_off_o,
  output logic [PAL_AW-1:0] pal_idx_o,
  output logic [EXT_AW-1:0] ext_addr_o
);
  logic [FOLD_W-1:0] a;
  assign a = addr_i[FOLD_W-1:0];

  always_comb begin
    tgt_o      = TGT_PAT;
    nt_page_o  = 1'b0;
    nt_off_o   = a[NT_AW-1:0];
    pal_idx_o  = a[PAL_AW-1:0];
    ext_addr_o = '0;
    if (!a[13]) begin
      tgt_o      = TGT_PAT;
      ext_addr_o = {bank_i, a[PAT_W-1:0]};
    end else if (a[13:8] == 6'h3F) begin
      tgt_o = TGT_PAL;
      // backdrop slots of the upper half fold onto the lower half
      if (a[1:0] == 2'b00) pal_idx_o[PAL_AW-1] = 1'b0;
    end else begin
      tgt_o = TGT_NT;
      unique case (mode_i)
        NT_HORZ: nt_page_o = a[11];
        NT_VERT: nt_page_o = a[10];
        NT_ONE:  nt_page_o = 1'b0;
        NT_FOUR: begin
          tgt_o      = TGT_XNT;
          ext_addr_o = {{(EXT_AW-XNT_W){1'b0}}, a[XNT_W-1:0]};
        end
        default: nt_page_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/vam_ntram.sv
module vam_ntram
  import vam_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic             we_i,
  input  logic             page_i,
  input  logic [NT_AW-1:0] off_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int DEPTH = 1 << NT_AW;

  logic [DW-1:0] rd_q [NT_PGS];
  logic          page_q;

  for (genvar g = 0; g < NT_PGS; g++) begin : g_page
    logic [DW-1:0] mem [DEPTH];
    logic          sel;
    assign sel = (page_i == g[0]);
    always_ff @(posedge clk_i) begin
      if (we_i && sel) mem[off_i] <= wdata_i;
      if (re_i && sel) rd_q[g] <= mem[off_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= 1'b0;
    else if (re_i) page_q <= page_i;
  end

  assign rdata_o = rd_q[page_q];

  a_r12_ntram_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_i && we_i));
endmodule

// File: rtl/vam_palram.sv
module vam_palram
  import vam_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [PAL_AW-1:0] idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int DEPTH = 1 << PAL_AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_q <= '0;
    end else begin
      if (we_i) mem[idx_i] <= wdata_i;
      if (re_i) rd_q <= mem[idx_i];
    end
  end

  assign rdata_o = rd_q;

  // R4: an aliased backdrop slot never reaches the upper half of the array
  a_r4_no_upper_backdrop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i || re_i) && idx_i[PAL_AW-1] |-> idx_i[1:0] != 2'b00);
endmodule

// File: rtl/vam_top.sv
module vam_top
  import vam_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BANK_W = 2,
  localparam int EXT_AW = BANK_W + PAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [VA_W-1:0]   addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [1:0]        mirror_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              pat_ro_i,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic              ext_nt_o,
  output logic [EXT_AW-1:0] ext_addr_o,
  output logic [DW-1:0]     ext_wdata_o,
  input  logic [DW-1:0]     ext_rdata_i
);
  tgt_e              tgt, tgt_q;
  logic              nt_page;
  logic [NT_AW-1:0]  nt_off;
  logic [PAL_AW-1:0] pal_idx;
  logic [DW-1:0]     nt_rdata, pal_rdata, ext_q;
  logic              rd, wr, is_ext, blocked, rvalid_q;

  vam_decode #(.BANK_W(BANK_W)) u_dec (
    .addr_i    (addr_i),
    .mode_i    (nt_map_e'(mirror_i)),
    .bank_i    (bank_i),
    .tgt_o     (tgt),
    .nt_page_o (nt_page),
    .nt_off_o  (nt_off),
    .pal_idx_o (pal_idx),
    .ext_addr_o(ext_addr_o)
  );

  assign rd      = req_i && !we_i;
  assign wr      = req_i && we_i;
  assign is_ext  = (tgt == TGT_PAT) || (tgt == TGT_XNT);
  assign blocked = wr && (tgt == TGT_PAT) && pat_ro_i;

  assign ext_req_o   = req_i && is_ext && !blocked;
  assign ext_we_o    = wr && is_ext && !blocked;
  assign ext_nt_o    = (tgt == TGT_XNT);
  assign ext_wdata_o = wdata_i;

  vam_ntram #(.DW(DW)) u_nt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .re_i   (rd && tgt == TGT_NT),
    .we_i   (wr && tgt == TGT_NT),
    .page_i (nt_page),
    .off_i  (nt_off),
    .wdata_i(wdata_i),
    .rdata_o(nt_rdata)
  );

  vam_palram #(.DW(DW)) u_pal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .re_i   (rd && tgt == TGT_PAL),
    .we_i   (wr && tgt == TGT_PAL),
    .idx_i  (pal_idx),
    .wdata_i(wdata_i),
    .rdata_o(pal_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q    <= TGT_PAT;
      ext_q    <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) tgt_q <= tgt;
      if (rd && is_ext) ext_q <= ext_rdata_i;
    end
  end

  assign rvalid_o = rvalid_q;

  always_comb begin
    unique case (tgt_q)
      TGT_NT:  rdata_o = nt_rdata;
      TGT_PAL: rdata_o = pal_rdata;
      default: rdata_o = ext_q;
    endcase
  end

  a_r12_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);
  a_r12_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  a_r11_ro_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_ro_i && ext_we_o |-> ext_nt_o);
  a_r9_four_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mirror_i == 2'b11 && addr_i[13:12] == 2'b10 |-> ext_req_o && ext_nt_o);
  a_r6_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mirror_i != 2'b11 && addr_i[13] |-> !ext_req_o);
  a_r10_pat_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !addr_i[13] |-> ext_req_o && !ext_nt_o);
endmodule

// File: tb/vam_top_tb.sv
module vam_top_tb;
  localparam int DW = 8;
  localparam int BANK_W = 2;
  localparam int EXT_AW = BANK_W + 13;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0;
  logic [15:0]       addr_i = '0;
  logic [DW-1:0]     wdata_i = '0;
  logic [1:0]        mirror_i = 2'b00;
  logic [BANK_W-1:0] bank_i = '0;
  logic              pat_ro_i = 1'b0;
  logic              rvalid_o, ext_req_o, ext_we_o, ext_nt_o;
  logic [DW-1:0]     rdata_o, ext_wdata_o, ext_rdata_i;
  logic [EXT_AW-1:0] ext_addr_o;

  int n_checks = 0;
  int n_errs = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk_i = ~clk_i;

  function automatic logic [7:0] ext_model(input logic nt, input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ (nt ? 8'hA5 : 8'h3C);
  endfunction

  assign ext_rdata_i = ext_model(ext_nt_o, 16'(ext_addr_o));

  vam_top #(.DW(DW), .BANK_W(BANK_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .mirror_i(mirror_i), .bank_i(bank_i), .pat_ro_i(pat_ro_i),
    .rvalid_o(rvalid_o), .rdata_o(rdata_o), .ext_req_o(ext_req_o), .ext_we_o(ext_we_o),
    .ext_nt_o(ext_nt_o), .ext_addr_o(ext_addr_o), .ext_wdata_o(ext_wdata_o),
    .ext_rdata_i(ext_rdata_i)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  endtask

  // monitor: results are due one rising edge after the request
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (rvalid_o) begin
        if (exp_q.size() == 0) check(32'(rvalid_o), 32'd0, "R12 unexpected rvalid");
        else check(32'(rdata_o), 32'(exp_q.pop_front()), tag_q.pop_front());
      end else if (exp_q.size() != 0) begin
        check(32'(rvalid_o), 32'd1, {tag_q[0], " missing rvalid"});
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
  endtask

  task automatic cfg(input logic [1:0] m, input logic [BANK_W-1:0] b, input logic ro);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    mirror_i = m; bank_i = b; pat_ro_i = ro;
  endtask

  task automatic xchk(input logic rq, input logic w, input logic nt,
                      input logic [EXT_AW-1:0] ea, input string tag);
    #1;
    check(32'(ext_req_o), 32'(rq), {tag, " ext_req"});
    check(32'(ext_we_o), 32'(w), {tag, " ext_we"});
    if (rq) begin
      check(32'(ext_nt_o), 32'(nt), {tag, " ext_nt"});
      check(32'(ext_addr_o), 32'(ea), {tag, " ext_addr"});
    end
  endtask

  initial begin
    #(8 * 100000);
    n_errs++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #3;
    check(32'(rvalid_o), 32'd0, "R13 rvalid in reset");
    check(32'(rdata_o), 32'd0, "R13 rdata in reset");
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    check(32'(rvalid_o), 32'd0, "R13 rvalid after reset");
    check(32'(rdata_o), 32'd0, "R13 rdata after reset");

    // horizontal
    cfg(2'b00, 2'd0, 1'b0);
    wr(16'h2000, 8'h11);
    xchk(1'b0, 1'b0, 1'b0, '0, "R6 internal write");
    rd(16'h2400, 8'h11, "R6 horiz 2400=2000");
    wr(16'h2800, 8'h22);
    rd(16'h2C00, 8'h22, "R6 horiz 2C00=2800");
    rd(16'h2000, 8'h11, "R6 horiz pages distinct");
    rd(16'h6000, 8'h11, "R1 fold 6000");
    rd(16'hE400, 8'h11, "R1 fold E400");
    wr(16'hA805, 8'h33);
    rd(16'h2C05, 8'h33, "R1 write via A805");
    rd(16'h3000, 8'h11, "R2 3000 alias");
    wr(16'h3E10, 8'h44);
    rd(16'h2E10, 8'h44, "R2 3E10 alias");
    wr(16'h2EFF, 8'h77);
    rd(16'h3EFF, 8'h77, "R2 3EFF boundary");
    wr(16'h2C07, 8'h66);
    wr(16'h2000, 8'h11);
    rd(16'h2000, 8'h11, "R12 write gives no rvalid");

    // vertical
    cfg(2'b01, 2'd0, 1'b0);
    rd(16'h2800, 8'h11, "R7 vert 2800=2000");
    rd(16'h2400, 8'h22, "R7 vert 2400 page1");
    rd(16'h2C00, 8'h22, "R7 vert 2C00 page1");

    // single page
    cfg(2'b10, 2'd0, 1'b0);
    rd(16'h2C00, 8'h11, "R8 single 2C00");
    rd(16'h2400, 8'h11, "R8 single 2400");

    // four page
    cfg(2'b11, 2'd0, 1'b0);
    wr(16'h2C07, 8'h55);
    xchk(1'b1, 1'b1, 1'b1, EXT_AW'(16'h0C07), "R9 four write");
    rd(16'h2C07, ext_model(1'b1, 16'h0C07), "R9 four read");
    xchk(1'b1, 1'b0, 1'b1, EXT_AW'(16'h0C07), "R9 four read");
    rd(16'h3C07, ext_model(1'b1, 16'h0C07), "R2 R9 3C07 alias");
    cfg(2'b00, 2'd0, 1'b0);
    rd(16'h2C07, 8'h66, "R9 internal page untouched");

    // palette
    wr(16'h3F00, 8'h01);
    wr(16'h3F04, 8'h02);
    wr(16'h3F08, 8'h03);
    wr(16'h3F0C, 8'h04);
    rd(16'h3F00, 8'h01, "R5 entry 00");
    rd(16'h3F04, 8'h02, "R5 entry 04");
    rd(16'h3F08, 8'h03, "R5 entry 08");
    rd(16'h3F0C, 8'h04, "R5 entry 0C");
    wr(16'h3F01, 8'h09);
    wr(16'h3F11, 8'h0A);
    rd(16'h3F01, 8'h09, "R4 entry 11 distinct from 01");
    rd(16'h3F14, 8'h02, "R4 3F14 alias");
    rd(16'h3F10, 8'h01, "R4 3F10 alias");
    wr(16'h3F1C, 8'h0E);
    rd(16'h3F0C, 8'h0E, "R4 write 3F1C lands on 0C");
    rd(16'h3F18, 8'h03, "R4 3F18 alias");
    rd(16'h3FE4, 8'h02, "R3 3FE4 repeat");
    rd(16'h3F31, 8'h0A, "R3 3F31 repeat");
    rd(16'hFF21, 8'h09, "R3 R1 FF21");

    // pattern memory
    cfg(2'b00, 2'd2, 1'b0);
    rd(16'h1234, ext_model(1'b0, 16'h5234), "R10 bank2 read");
    xchk(1'b1, 1'b0, 1'b0, EXT_AW'(16'h5234), "R10 bank2");
    cfg(2'b00, 2'd1, 1'b0);
    rd(16'h5FFF, ext_model(1'b0, 16'h3FFF), "R10 R1 bank1 5FFF");
    xchk(1'b1, 1'b0, 1'b0, EXT_AW'(16'h3FFF), "R10 bank1");
    cfg(2'b00, 2'd2, 1'b1);
    wr(16'h0100, 8'hAB);
    xchk(1'b0, 1'b0, 1'b0, '0, "R11 read-only write blocked");
    cfg(2'b00, 2'd2, 1'b0);
    wr(16'h0100, 8'hAB);
    xchk(1'b1, 1'b1, 1'b0, EXT_AW'(16'h4100), "R11 writable");
    check(32'(ext_wdata_o), 32'hAB, "R11 write data");

    cfg(2'b00, 2'd0, 1'b0);
    repeat (3) @(negedge clk_i);
    check(32'(exp_q.size()), 32'd0, "R12 queue drained");
    summary();
  end
endmodule